// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block masters an external memory and I/O bus where address and data share one set of wires. A client presents a transfer on a simple request port: address, write data, a direction flag and a stretch flag. The controller then runs a fixed sequence. It drives the address, pulses an active-low address strobe (`as_n`) so that external latches capture it, and turns the shared bus around. It then holds the active-low data strobe (`ds_n`) low for a window whose length depends on direction. Finally it waits through a recovery gap and reports completion with a one-cycle `done` pulse. Read data is captured on the clock edge where `ds_n` returns high and stays on `rdata` until the next read.

The data strobe window is longer for reads than for writes, at a ratio of about two to one. A stretch flag, sampled together with the request, lengthens the window of that one transfer by a fixed number of clocks. Pad drivers and drive strength sit outside the block: the shared bus reaches the block as `bus_out`, `bus_oe` and `bus_in`.

Top module: `mxbus_ctrl`

## Requirements
- R1: During and after reset, with no request pending: `as_n`=1, `ds_n`=1, `rw_n`=1, `bus_oe`=0, `done`=0 and `req_ready`=1.
- R2: A request is taken only on a clock edge where `req_ready`=1 and `req_valid`=1. `req_valid` has no effect while `req_ready`=0, including during the `done` cycle.
- R3: After acceptance, `bus_oe`=1 and `bus_out` equals the address for three cycles. `as_n` is high in the first, low in the second and high again in the third.
- R4: `rw_n` carries the direction (1 = read, 0 = write) from the first address cycle through the `done` cycle. It reads 1 when idle.
- R5: For a read, `bus_oe` is 0 from the cycle after the address phase, which is one full cycle before `ds_n` falls, through `done`.
- R6: `ds_n` stays low for exactly RD_CYC (default 4) consecutive cycles on a read and WR_CYC (default 2) on a write.
- R7: When `req_ext`=1 at acceptance, the `ds_n` low window of that transfer grows by EXT_CYC (default 2) cycles.
- R8: For a write, `bus_oe`=1 and `bus_out` equals the write data from one cycle before `ds_n` falls through the `done` cycle.
- R9: `rdata` takes the value of `bus_in` at the clock edge on which `ds_n` rises. It is valid with `done` and holds unchanged until the next read completes.
- R10: `done` is high for exactly one cycle: the RCV_CYC-th (default 2nd) cycle after `ds_n` rises. `req_ready` returns high on the next cycle.
- R11: `as_n` is low for exactly one cycle per transfer and is never low in the same cycle as `ds_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_ext | input | 1 | Stretch the data window of this transfer |
| req_addr | input | BW | Transfer address |
| req_wdata | input | BW | Write data |
| req_ready | output | 1 | Controller idle, request will be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | BW | Captured read data |
| bus_out | output | BW | Value driven onto the shared bus |
| bus_oe | output | 1 | Shared bus output enable |
| bus_in | input | BW | Value seen on the shared bus |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rw_n | output | 1 | Direction line, 1 = read |

## Verification
The completion pulse and a fresh request can share a cycle. The bench provokes this by holding `req_valid` high, with unrelated fields, from just after one acceptance through the whole transfer. It drops the request only in the idle cycle that follows `done`. The reference model accepts only in idle cycles, so any capture of those fields or any shortened turnaround shows up as a strobe, bus or `done` mismatch. Read capture and the rising edge of `ds_n` also fall on the same edge. The bench drives the intended value on `bus_in` only in the last low cycle of `ds_n` and drives its complement at all other times, so a capture one cycle early or late is caught.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_ASLO = 3'd2,
        ST_ASHI = 3'd3,
        ST_TURN = 3'd4,
        ST_DATA = 3'd5,
        ST_RECV = 3'd6
    } mx_state_e;

endpackage

// File: rtl/mxbus_phase_len.sv
module mxbus_phase_len #(
    parameter int RD_CYC  = 4,
    parameter int WR_CYC  = 2,
    parameter int EXT_CYC = 2,
    parameter int CW      = 3
) (
    input  logic          rd,
    input  logic          ext,
    output logic [CW-1:0] dlast
);

    localparam logic [CW-1:0] RD_LAST = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] WR_LAST = CW'(WR_CYC - 1);
    localparam logic [CW-1:0] EXT_ADD = CW'(EXT_CYC);

    always_comb begin
        dlast = rd ? RD_LAST : WR_LAST;
        if (ext) begin
            dlast = dlast + EXT_ADD;
        end
    end

    initial begin
        assert (RD_CYC >= WR_CYC && WR_CYC >= 1) else $error("phase length parameters");
    end

endmodule

// File: rtl/mxbus_rdcap.sv
module mxbus_rdcap #(
    parameter int BW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [BW-1:0] bus_in,
    output logic [BW-1:0] rdata
);

    logic [BW-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (cap_en) begin
            rdata_d = bus_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    // R9: captured data only changes on a capture edge
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(rdata_q));

endmodule

// File: rtl/mxbus_seq.sv
module mxbus_seq
    import mxbus_pkg::*;
#(
    parameter int BW      = 16,
    parameter int RD_CYC  = 4,
    parameter int WR_CYC  = 2,
    parameter int EXT_CYC = 2,
    parameter int RCV_CYC = 2,
    parameter int CW      = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_rd,
    input  logic          req_ext,
    input  logic [BW-1:0] req_addr,
    input  logic [BW-1:0] req_wdata,
    input  logic [CW-1:0] dlast,
    output logic          cur_rd,
    output logic          cur_ext,
    output logic          req_ready,
    output logic          done,
    output logic          cap_en,
    output logic [BW-1:0] bus_out,
    output logic          bus_oe,
    output logic          as_n,
    output logic          ds_n,
    output logic          rw_n
);

    localparam logic [CW-1:0] RCV_LAST = CW'(RCV_CYC - 1);

    typedef struct packed {
        mx_state_e     st;
        logic [CW-1:0] cnt;
        logic          rd;
        logic          ext;
        logic [BW-1:0] addr;
        logic [BW-1:0] wdata;
    } seq_t;

    seq_t d, q;

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st    = ST_ADDR;
                    d.rd    = req_rd;
                    d.ext   = req_ext;
                    d.addr  = req_addr;
                    d.wdata = req_wdata;
                end
            end
            ST_ADDR: d.st = ST_ASLO;
            ST_ASLO: d.st = ST_ASHI;
            ST_ASHI: d.st = ST_TURN;
            ST_TURN: begin
                d.st  = ST_DATA;
                d.cnt = '0;
            end
            ST_DATA: begin
                if (q.cnt == dlast) begin
                    d.st  = ST_RECV;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_RECV: begin
                if (q.cnt == RCV_LAST) begin
                    d.st  = ST_IDLE;
                    d.cnt = '0;
                    d.rd  = 1'b1;
                    d.ext = 1'b0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.rd    <= 1'b1;
        end else begin
            q <= d;
        end
    end

    logic addr_phase;
    assign addr_phase = (q.st == ST_ADDR) || (q.st == ST_ASLO) || (q.st == ST_ASHI);

    assign cur_rd    = q.rd;
    assign cur_ext   = q.ext;
    assign req_ready = (q.st == ST_IDLE);
    assign done      = (q.st == ST_RECV) && (q.cnt == RCV_LAST);
    assign cap_en    = (q.st == ST_DATA) && (q.cnt == dlast) && q.rd;
    assign as_n      = (q.st != ST_ASLO);
    assign ds_n      = (q.st != ST_DATA);
    assign rw_n      = q.rd;
    assign bus_oe    = addr_phase || (!q.rd && (q.st != ST_IDLE));
    assign bus_out   = addr_phase ? q.addr : q.wdata;

    // Length of the data strobe window, counted independently of the sequencer
    logic [CW:0] ds_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ds_run_q <= '0;
        else if (ds_n)  ds_run_q <= '0;
        else            ds_run_q <= ds_run_q + 1'b1;
    end

    // R6 R7: window length matches direction plus stretch
    a_r6_ds_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ds_n) |-> (int'(ds_run_q) ==
            ((q.rd ? RD_CYC : WR_CYC) + (q.ext ? EXT_CYC : 0))));

    // R11: single-cycle address strobe, never overlapping the data strobe
    a_r11_as_single: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n |=> as_n);
    a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!as_n && !ds_n));

    // R5: bus released while a read strobe is low
    a_r5_read_float: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_n && rw_n) |-> !bus_oe);

    // R8: bus driven throughout a write strobe
    a_r8_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_n && !rw_n) |-> bus_oe);

    // R4: direction unchanged across the data strobe rising edge
    a_r4_rw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ds_n) |-> $stable(rw_n));

    // R10: one-cycle done, idle follows
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

endmodule

// File: rtl/mxbus_ctrl.sv
module mxbus_ctrl #(
    parameter int BW      = 16,
    parameter int RD_CYC  = 4,
    parameter int WR_CYC  = 2,
    parameter int EXT_CYC = 2,
    parameter int RCV_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_rd,
    input  logic          req_ext,
    input  logic [BW-1:0] req_addr,
    input  logic [BW-1:0] req_wdata,
    output logic          req_ready,
    output logic          done,
    output logic [BW-1:0] rdata,
    output logic [BW-1:0] bus_out,
    output logic          bus_oe,
    input  logic [BW-1:0] bus_in,
    output logic          as_n,
    output logic          ds_n,
    output logic          rw_n
);

    localparam int LONG = ((RD_CYC > WR_CYC) ? RD_CYC : WR_CYC) + EXT_CYC;
    localparam int MAXL = (LONG > RCV_CYC) ? LONG : RCV_CYC;
    localparam int CW   = $clog2(MAXL + 1);

    logic          cur_rd, cur_ext, cap_en;
    logic [CW-1:0] dlast;

    mxbus_phase_len #(
        .RD_CYC (RD_CYC),
        .WR_CYC (WR_CYC),
        .EXT_CYC(EXT_CYC),
        .CW     (CW)
    ) u_len (
        .rd   (cur_rd),
        .ext  (cur_ext),
        .dlast(dlast)
    );

    mxbus_seq #(
        .BW     (BW),
        .RD_CYC (RD_CYC),
        .WR_CYC (WR_CYC),
        .EXT_CYC(EXT_CYC),
        .RCV_CYC(RCV_CYC),
        .CW     (CW)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_rd   (req_rd),
        .req_ext  (req_ext),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .dlast    (dlast),
        .cur_rd   (cur_rd),
        .cur_ext  (cur_ext),
        .req_ready(req_ready),
        .done     (done),
        .cap_en   (cap_en),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe),
        .as_n     (as_n),
        .ds_n     (ds_n),
        .rw_n     (rw_n)
    );

    mxbus_rdcap #(
        .BW(BW)
    ) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .cap_en(cap_en),
        .bus_in(bus_in),
        .rdata (rdata)
    );

endmodule

// File: tb/mxbus_ctrl_tb.sv
module mxbus_ctrl_tb;

    localparam int BW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_rd = 1'b0;
    logic          req_ext = 1'b0;
    logic [BW-1:0] req_addr = '0;
    logic [BW-1:0] req_wdata = '0;
    logic          req_ready, done, bus_oe, as_n, ds_n, rw_n;
    logic [BW-1:0] rdata, bus_out;
    logic [BW-1:0] bus_in = '0;

    always #4 clk = ~clk;

    mxbus_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rd(req_rd),
        .req_ext(req_ext), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rdata(rdata), .bus_out(bus_out),
        .bus_oe(bus_oe), .bus_in(bus_in), .as_n(as_n), .ds_n(ds_n), .rw_n(rw_n)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Reference model: position t within a transfer
    // 0 addr, 1 /AS low, 2 addr hold, 3 turnaround, 4..4+N-1 data, then RCV recovery
    bit            m_act = 0, m_rd = 0, m_ext = 0;
    int            m_t = 0, m_n = 0, m_end = 0;
    logic [BW-1:0] m_addr = '0, m_wd = '0, m_rv = '0, m_last = '0;
    logic [BW-1:0] next_rv = '0;

    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (m_act) begin
                if (m_t == m_end) begin
                    m_act = 0;
                    if (m_rd) m_last = m_rv;
                end else begin
                    m_t++;
                end
            end else if (req_valid) begin
                m_act  = 1;
                m_t    = 0;
                m_rd   = req_rd;
                m_ext  = req_ext;
                m_addr = req_addr;
                m_wd   = req_wdata;
                m_rv   = next_rv;
                m_n    = (req_rd ? 4 : 2) + (req_ext ? 2 : 0);
                m_end  = 4 + m_n + 2 - 1;
            end
            if (!m_act) begin
                chk("R2 ready idle", req_ready, 1);
                chk("R11 as_n idle", as_n, 1);
                chk("R6 ds_n idle", ds_n, 1);
                chk("R4 rw_n idle", rw_n, 1);
                chk("R5 bus_oe idle", bus_oe, 0);
                chk("R10 done idle", done, 0);
            end else begin
                chk("R2 ready busy", req_ready, 0);
                chk("R3 R11 as_n", as_n, (m_t != 1));
                chk("R6 R7 ds_n", ds_n, !(m_t >= 4 && m_t < 4 + m_n));
                chk("R4 rw_n", rw_n, m_rd);
                chk("R5 R8 bus_oe", bus_oe, (m_t <= 2) ? 1 : !m_rd);
                if (m_t <= 2) chk("R3 address on bus", bus_out, m_addr);
                else if (!m_rd) chk("R8 write data on bus", bus_out, m_wd);
                chk("R10 done", done, (m_t == m_end));
                if (m_t == m_end)
                    chk("R9 rdata with done", rdata, m_rd ? m_rv : m_last);
            end
        end
        // drive the intended read value only in the last strobe-low cycle
        if (m_act && m_rd && m_t == 4 + m_n - 1) bus_in <= m_rv;
        else if (m_act && m_rd)                bus_in <= ~m_rv;
        else                                   bus_in <= 16'h5A5A;
    end

    // Caller is at a negedge
    task automatic xfer(input bit rd, input bit ext, input logic [BW-1:0] addr,
                        input logic [BW-1:0] wd, input logic [BW-1:0] rv, input bit noise);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_rd = rd; req_ext = ext; req_addr = addr; req_wdata = wd;
        next_rv = rv;
        @(negedge clk);
        if (noise) begin
            // R2: a busy-time request with different fields, held across done
            req_rd = !rd; req_ext = !ext; req_addr = ~addr; req_wdata = ~wd;
            while (!req_ready) @(negedge clk);
        end
        req_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset as_n", as_n, 1);
        chk("R1 reset ds_n", ds_n, 1);
        chk("R1 reset bus_oe", bus_oe, 0);
        chk("R1 reset ready", req_ready, 1);
        chk("R1 reset done", done, 0);
        chk("R1 reset rw_n", rw_n, 1);
        rst_n = 1;
        repeat (2) @(negedge clk);
        xfer(1, 0, 16'h1234, 16'h0000, 16'hBEEF, 0);   // R6 read
        repeat (3) @(negedge clk);
        xfer(0, 0, 16'hFFFF, 16'hA55A, 16'h0000, 0);   // R8 write
        repeat (2) @(negedge clk);
        xfer(1, 1, 16'h0000, 16'h0000, 16'hC3C3, 0);   // R7 stretched read
        xfer(0, 1, 16'h8001, 16'h7E7E, 16'h0000, 0);   // R7 stretched write
        xfer(1, 0, 16'h4242, 16'h1111, 16'h0F0F, 1);   // R2 noise on read
        xfer(0, 0, 16'h00FF, 16'hFF00, 16'h0000, 1);   // R2 noise on write
        xfer(0, 1, 16'h2468, 16'h1357, 16'h0000, 0);   // back to back
        xfer(1, 1, 16'h9999, 16'h0000, 16'hFFFF, 0);
        xfer(1, 0, 16'h7777, 16'h0000, 16'h0001, 0);
        while (!req_ready) @(negedge clk);
        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

endmodule